// File: doc/BRIEF.md
# Single-Wire Bus Clock Master

This block is the clock source for a wired-AND single-wire bus. The line is open drain: every node can only pull it low, and a pull-up brings it high. When the block is switched on it sends a steady stream of idle clock symbols. Each bit starts with a short low pulse driven by the master and ends with the line released high. Rising edges are therefore exactly one bit period apart. When it is switched off, the block releases the line for good and the bus stays high, which the rest of the system may use as a low-power state.

The master decides the moment of every rising edge, but a slow bus or a slave can hold the line low after the master lets go. The block therefore watches the line through a two-stage synchronizer. It measures how many ticks each low stretch lasts and grades the result in three steps:

- an early warning when the edge is an eighth of a bit late;
- a protocol violation when the edge is half a bit late;
- a slave exception when the line stays low for two whole bit periods or more.

The three flags are sticky and are cleared together by a single pulse.

All timing is counted in ticks of an enable input. One bit period is `BIT_TICKS` ticks, and that value must be a multiple of 8. Ticks must be at least two system clocks apart so that the synchronizer delay stays inside one tick.

Top module: `bus_clk_master`

## Requirements
- R1: After reset the block is passive: `active_o`=0, `drive_low_o`=0, and all three flags are 0.
- R2: While active, every bit lasts `BIT_TICKS` ticks. The line is driven low (`drive_low_o`=1) for the first `BIT_TICKS/4` ticks of each bit and released for the rest of the bit.
- R3: While passive, `drive_low_o` stays 0 whatever the other inputs do.
- R4: Dropping `run_req` in the middle of a bit does not cut that bit short. The block goes passive only at the tick that ends the current bit.
- R5: When `run_req` is seen on a tick while the block is passive, the block becomes active and starts a bit with its low phase at that same tick.
- R6: `late_warn_o` is set once a single low stretch of the line reaches `BIT_TICKS/4 + BIT_TICKS/8` ticks, which means the rising edge is at least 1/8 bit late.
- R7: `violation_o` is set when a low stretch ends after lasting at least `BIT_TICKS/4 + BIT_TICKS/2` ticks but fewer than `2*BIT_TICKS` ticks.
- R8: `slv_exc_o` is set once a low stretch reaches `2*BIT_TICKS` ticks. A stretch that long does not set `violation_o`.
- R9: Each flag stays set until `clr_flags` is pulsed. A clear and a new event in the same cycle leave the flag set.
- R10: A low stretch that ends on time, one that no other node extends, sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Tick enable; one tick is 1/BIT_TICKS of a bit |
| run_req | input | 1 | 1 requests the Active state, 0 requests Passive |
| clr_flags | input | 1 | Pulse that clears all status flags |
| line_i | input | 1 | Level seen on the bus line (asynchronous) |
| drive_low_o | output | 1 | 1 pulls the open-drain line low |
| active_o | output | 1 | 1 while the clock stream is being sent |
| late_warn_o | output | 1 | Sticky: a rising edge came 1/8 bit late |
| violation_o | output | 1 | Sticky: a rising edge came 1/2 bit late |
| slv_exc_o | output | 1 | Sticky: the line was held low for two bit periods |

## Verification
The assertions watch several rules on every cycle:
- the drive output rises only on a tick;
- the Active state ends only when the line is released at a tick;
- the flags stay set until a clear, and a clear with no tick empties them;
- an exception never arrives together with a new violation.

How long each phase lasts, which flags a given late edge produces, and the fact that the last bit is never shortened can only be shown by the bench's scenarios. In those scenarios a slave model stretches the low phase by 0, 1/8, 1/2 and 2 bit periods, and the bench measures pulse widths and stop latency in clocks.

// File: rtl/bcm_pkg.sv
`timescale 1ns/1ps
package bcm_pkg;

  typedef enum logic {
    BCM_PASSIVE = 1'b0,
    BCM_ACTIVE  = 1'b1
  } bcm_state_e;

  typedef struct packed {
    logic exc;
    logic vio;
    logic warn;
  } bcm_flags_t;

endpackage

// File: rtl/bcm_sync.sv
`timescale 1ns/1ps
module bcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d_i;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  // idle bus level is high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/bcm_bit_timer.sv
`timescale 1ns/1ps
module bcm_bit_timer
  import bcm_pkg::*;
#(
  parameter int BIT_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run_req,
  output logic active_o,
  output logic drive_low_o
);

  localparam int CNTW = $clog2(BIT_TICKS);
  localparam logic [CNTW-1:0] LAST_T = CNTW'(BIT_TICKS - 1);
  localparam logic [CNTW-1:0] LOW_T  = CNTW'(BIT_TICKS / 4);

  bcm_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            drv_q, drv_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (tick_en) begin
      unique case (state_q)
        BCM_PASSIVE: begin
          cnt_d = '0;
          if (run_req) state_d = BCM_ACTIVE;
        end
        BCM_ACTIVE: begin
          if (cnt_q == LAST_T) begin
            cnt_d = '0;
            if (!run_req) state_d = BCM_PASSIVE;
          end else begin
            cnt_d = cnt_q + CNTW'(1);
          end
        end
        default: state_d = BCM_PASSIVE;
      endcase
    end
    // registered drive avoids decode glitches on the line
    drv_d = (state_d == BCM_ACTIVE) && (cnt_d < LOW_T);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BCM_PASSIVE;
      cnt_q   <= '0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drv_q   <= drv_d;
    end
  end

  assign active_o    = (state_q == BCM_ACTIVE);
  assign drive_low_o = drv_q;

endmodule

// File: rtl/bcm_edge_monitor.sv
`timescale 1ns/1ps
module bcm_edge_monitor
  import bcm_pkg::*;
#(
  parameter int BIT_TICKS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       line_s,
  input  logic       clr_flags,
  output bcm_flags_t flags_o
);

  localparam int LOW_TICKS = BIT_TICKS / 4;
  localparam int CW        = $clog2(2 * BIT_TICKS + 1);
  localparam logic [CW-1:0] WARN_T = CW'(LOW_TICKS + BIT_TICKS / 8);
  localparam logic [CW-1:0] VIO_T  = CW'(LOW_TICKS + BIT_TICKS / 2);
  localparam logic [CW-1:0] EXC_T  = CW'(2 * BIT_TICKS);

  logic [CW-1:0] run_q, run_d;
  bcm_flags_t    flg_q, flg_d, set;
  logic          run_ends;

  always_comb begin
    run_d    = run_q;
    run_ends = 1'b0;
    if (tick_en) begin
      if (!line_s) begin
        run_d = (run_q == EXC_T) ? run_q : run_q + CW'(1);
      end else begin
        run_d    = '0;
        run_ends = (run_q != '0);
      end
    end
    set.warn = tick_en && !line_s && (run_d >= WARN_T);
    set.exc  = tick_en && !line_s && (run_d >= EXC_T);
    set.vio  = run_ends && (run_q >= VIO_T) && (run_q < EXC_T);
    // a new event beats a simultaneous clear
    flg_d = clr_flags ? set : (flg_q | set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      flg_q <= '0;
    end else begin
      run_q <= run_d;
      flg_q <= flg_d;
    end
  end

  assign flags_o = flg_q;

endmodule

// File: rtl/bus_clk_master.sv
`timescale 1ns/1ps
module bus_clk_master
  import bcm_pkg::*;
#(
  parameter int BIT_TICKS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run_req,
  input  logic clr_flags,
  input  logic line_i,
  output logic drive_low_o,
  output logic active_o,
  output logic late_warn_o,
  output logic violation_o,
  output logic slv_exc_o
);

  logic       line_s;
  bcm_flags_t flags;

  bcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  bcm_bit_timer #(.BIT_TICKS(BIT_TICKS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .run_req     (run_req),
    .active_o    (active_o),
    .drive_low_o (drive_low_o)
  );

  bcm_edge_monitor #(.BIT_TICKS(BIT_TICKS)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .line_s    (line_s),
    .clr_flags (clr_flags),
    .flags_o   (flags)
  );

  assign late_warn_o = flags.warn;
  assign violation_o = flags.vio;
  assign slv_exc_o   = flags.exc;

endmodule

// File: rtl/bcm_checker.sv
`timescale 1ns/1ps
module bcm_checker (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic clr_flags,
  input logic drive_low_o,
  input logic active_o,
  input logic late_warn_o,
  input logic violation_o,
  input logic slv_exc_o
);

  // R2: bit phases only move on a tick
  p_drive_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low_o) |-> $past(tick_en));

  // R3: passive never pulls the line
  p_passive_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !drive_low_o);

  // R4: stop only at a tick, from the released phase
  p_stop_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> ($past(tick_en) && !$past(drive_low_o)));

  // R6: warning is raised by a tick
  p_warn_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_warn_o) |-> $past(tick_en));

  // R8: an exception never comes with a fresh violation
  p_exc_not_vio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_exc_o) |-> !$rose(violation_o));

  // R9: flags hold without a clear
  p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (late_warn_o && !clr_flags) |=> late_warn_o);
  p_vio_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (violation_o && !clr_flags) |=> violation_o);
  p_exc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_exc_o && !clr_flags) |=> slv_exc_o);

  // R9: a clear with no tick empties every flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags && !tick_en) |=> (!late_warn_o && !violation_o && !slv_exc_o));

endmodule

bind bus_clk_master bcm_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .clr_flags   (clr_flags),
  .drive_low_o (drive_low_o),
  .active_o    (active_o),
  .late_warn_o (late_warn_o),
  .violation_o (violation_o),
  .slv_exc_o   (slv_exc_o)
);

// File: tb/bus_clk_master_tb_top.sv
`timescale 1ns/1ps
module bus_clk_master_tb_top;

  localparam int BIT   = 32;
  localparam int LOW   = BIT / 4;
  localparam int CPT   = 2;  // clocks per tick

  typedef struct {
    string      req;
    string      what;
    logic [2:0] exp;  // {exception, violation, warning}
  } exp_t;

  logic clk, rst_n, tick_en, run_req, clr_flags, line_i;
  logic drive_low_o, active_o, late_warn_o, violation_o, slv_exc_o;

  int   n_tests, n_fail;
  bit   done;
  exp_t sb_q[$];

  // slave model
  logic armed;
  int   stretch_ticks;
  int   hold;
  logic prev_drv;
  logic slave_pull;

  bus_clk_master #(.BIT_TICKS(BIT)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .run_req     (run_req),
    .clr_flags   (clr_flags),
    .line_i      (line_i),
    .drive_low_o (drive_low_o),
    .active_o    (active_o),
    .late_warn_o (late_warn_o),
    .violation_o (violation_o),
    .slv_exc_o   (slv_exc_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  always @(negedge clk) begin
    if (!rst_n) tick_en <= 1'b0;
    else        tick_en <= ~tick_en;
  end

  assign slave_pull = (armed && drive_low_o) || (hold > 0);
  assign line_i     = !(drive_low_o || slave_pull);

  always @(negedge clk) begin
    prev_drv <= drive_low_o;
    if (armed && prev_drv && !drive_low_o) begin
      hold  <= stretch_ticks * CPT;
      armed <= 1'b0;
    end else if (hold > 0) begin
      hold <= hold - 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.req, e.what, int'({slv_exc_o, violation_o, late_warn_o}), int'(e.exp));
    end
  end

  task automatic expect_flags(string req, string what, logic [2:0] exp);
    exp_t e;
    e.req = req; e.what = what; e.exp = exp;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    clr_flags = 1'b1;
    @(negedge clk);
    clr_flags = 1'b0;
    wait_clk(2);
  endtask

  task automatic stretch_case(int s, string req, string what, logic [2:0] exp);
    pulse_clear();
    stretch_ticks = s;
    armed = 1'b1;
    wait_clk(5 * BIT * CPT);
    expect_flags(req, what, exp);
  endtask

  initial begin
    #1600000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lo, per, n;
    bit seen_low;
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; run_req = 1'b0; clr_flags = 1'b0;
    armed = 1'b0; stretch_ticks = 0; hold = 0; prev_drv = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(1);

    // R1 reset state
    check("R1", "active after reset", int'(active_o), 0);
    check("R1", "drive after reset", int'(drive_low_o), 0);
    check("R1", "flags after reset", int'({slv_exc_o, violation_o, late_warn_o}), 0);

    // R5 start
    run_req = 1'b1;
    wait_clk(3);
    check("R5", "active after request", int'(active_o), 1);
    check("R5", "low phase at start", int'(drive_low_o), 1);

    // R2 low width and bit period, in clocks
    while (drive_low_o) @(negedge clk);
    while (!drive_low_o) @(negedge clk);
    lo = 0;
    while (drive_low_o) begin @(negedge clk); lo++; end
    per = lo;
    while (!drive_low_o) begin @(negedge clk); per++; end
    check("R2", "low phase clocks", lo, LOW * CPT);
    check("R2", "bit period clocks", per, BIT * CPT);

    // R10 on-time edges
    pulse_clear();
    wait_clk(4 * BIT * CPT);
    expect_flags("R10", "no stretch", 3'b000);

    // R6, R7, R8 graded lateness
    stretch_case(BIT / 8, "R6", "1/8 bit late", 3'b001);
    stretch_case(BIT / 2, "R7", "1/2 bit late", 3'b011);
    stretch_case(2 * BIT, "R8", "2 bits low", 3'b101);

    // R9 sticky, then clear
    wait_clk(3 * BIT * CPT);
    expect_flags("R9", "flags held", 3'b101);
    pulse_clear();
    expect_flags("R9", "flags cleared", 3'b000);

    // R4 stop mid-bit completes the bit
    while (drive_low_o) @(negedge clk);
    while (!drive_low_o) @(negedge clk);
    while (drive_low_o) @(negedge clk);
    run_req = 1'b0;
    n = 0; seen_low = 1'b0;
    while (active_o && n < 4 * BIT * CPT) begin
      @(negedge clk);
      n++;
      if (drive_low_o) seen_low = 1'b1;
    end
    check("R4", "clocks from release to passive", n, (BIT - LOW) * CPT);
    check("R4", "no new low phase before stop", int'(seen_low), 0);

    // R3 passive stays released
    seen_low = 1'b0;
    repeat (4 * BIT * CPT) begin
      @(negedge clk);
      if (drive_low_o) seen_low = 1'b1;
    end
    check("R3", "drive while passive", int'(seen_low), 0);
    check("R3", "state while passive", int'(active_o), 0);

    while (sb_q.size() > 0) @(negedge clk);
    wait_clk(2);
    finish_run();
  end

endmodule